// File: doc/BRIEF.md
# Idle-Locked Two-Lane Descrambler

This block restores plain bits from a line that a free-running additive scrambler has whitened. The scrambler's key stream comes from an 11-stage linear feedback register. While the link is idle the plain data is all ones, so every received bit, inverted, is a key bit. The block shifts these inferred key bits into its own register until that register copies the transmitter's key. From then on it predicts each key bit and XORs it onto the line.

Each clock can carry zero, one or two received bits, each on its own lane with its own valid flag. Lane 0 is processed before lane 1. The block counts consecutive received bits that decode to idle. Once the run is long enough it asserts lock and stops learning from the line. Lock holds until the signal-present input falls. A test-mode input shortens the required run so that a simulation can reach lock in a few cycles.

Top module: `dsc_idle_descrambler`

## Requirements
- R1: Key register stages are numbered 0 (newest) to 10. The predicted key bit is stage 8 XOR stage 10. The plain bit of a valid lane is the received bit XOR the predicted key bit at the moment that lane is processed.
- R2: `plain_valid` equals the `rx_valid` of the previous clock. A lane that is not valid does not shift the key register, and its `plain_bits` output is 0.
- R3: Valid lanes are processed in the order lane 0, then lane 1, with one key shift per valid lane. After lock, the decoded bits equal the plaintext that was scrambled.
- R4: While unlocked, each valid lane shifts the inverse of its received bit into the key register. A lane that decodes to 1 increments the agreement count, which saturates at the normal limit. A lane that decodes to 0 clears the count.
- R5: `locked` rises at the clock edge where the agreement count reaches 32 in normal mode. After that it stays high while `sig_present` is high. Once locked, the predicted bit is shifted into the key register instead of the inferred bit.
- R6: If `sig_present` is low during a clock, `locked` is low and the count is 0 after that edge. That clock's lanes are processed as if unlocked.
- R7: With `test_mode` high, the lock threshold is 4 agreeing bits instead of 32.
- R8: While `rst_n` is low and after it, the key register is 0, `locked` is 0, and both `plain_valid` and `plain_bits` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_present | input | 1 | Line signal is present |
| rx_bits | input | 2 | Received scrambled bits; bit 0 is lane 0 |
| rx_valid | input | 2 | Per-lane valid flags |
| test_mode | input | 1 | Selects the short lock threshold |
| plain_bits | output | 2 | Descrambled bits, registered |
| plain_valid | output | 2 | Per-lane valid flags for `plain_bits` |
| locked | output | 1 | Lock indication |

## Verification
The assertions check four rules on every cycle:
- output valids follow input valids one cycle later;
- the key register stays put on a clock with no valid lane;
- lock rises only on a clock where the agreement run hit its limit, and is then held while the signal is present;
- lock drops after any clock with the signal absent.

The exact cycle of lock acquisition, the lane ordering and the correctness of decoded data after lock can only be shown by the bench's scenarios. The bench scrambles known plaintext under mixed lane patterns, mismatch bursts, signal drops and test mode, and compares the decoded output with that plaintext.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int KEY_LEN = 11;
  localparam int TAP_A   = 8;
  localparam int TAP_B   = 10;

  typedef logic [KEY_LEN-1:0] key_t;

  // Key bit the generator will produce next from the current register.
  function automatic logic key_predict(key_t k);
    return k[TAP_A] ^ k[TAP_B];
  endfunction

  // Shift a new bit in at stage 0.
  function automatic key_t key_shift(key_t k, logic b);
    return {k[KEY_LEN-2:0], b};
  endfunction
endpackage

// File: rtl/dsc_lane_step.sv
module dsc_lane_step
  import dsc_pkg::*;
(
  input  key_t key_in,
  input  logic locked,
  input  logic rx_bit,
  input  logic rx_vld,
  output key_t key_out,
  output logic plain,
  output logic agree,
  output logic miss
);
  logic pred;
  logic ins_bit;

  always_comb begin
    pred    = key_predict(key_in);
    plain   = rx_vld & (rx_bit ^ pred);
    // R4: unlocked learns inverted line bit; R5: locked free-runs on prediction
    ins_bit = locked ? pred : ~rx_bit;
    key_out = rx_vld ? key_shift(key_in, ins_bit) : key_in;
    agree   = rx_vld & (rx_bit ^ pred);
    miss    = rx_vld & ~(rx_bit ^ pred);
  end
endmodule

// File: rtl/dsc_lock_ctrl.sv
module dsc_lock_ctrl #(
  parameter int LANES    = 2,
  parameter int LOCK_RUN = 32,
  parameter int TEST_RUN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_present,
  input  logic             test_mode,
  input  logic [LANES-1:0] agree,
  input  logic [LANES-1:0] miss,
  output logic             locked
);
  localparam int CW = $clog2(LOCK_RUN + 1);

  logic [CW-1:0] cnt_q, cnt_next, limit;
  logic          locked_q, run_hit;

  // R4: lanes are taken in order, each either extends or breaks the run
  always_comb begin
    cnt_next = cnt_q;
    for (int i = 0; i < LANES; i++) begin
      if (agree[i]) begin
        if (cnt_next < CW'(LOCK_RUN)) cnt_next = cnt_next + 1'b1;
      end else if (miss[i]) begin
        cnt_next = '0;
      end
    end
    limit   = test_mode ? CW'(TEST_RUN) : CW'(LOCK_RUN);  // R7
    run_hit = (cnt_next >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!sig_present) begin  // R6
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (!locked_q) cnt_q <= cnt_next;
      locked_q <= locked_q | run_hit;  // R5
    end
  end

  assign locked = locked_q;

  a_r5_lock_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(run_hit));
  a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && sig_present) |=> locked_q);
  a_r6_drop_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_present |=> !locked_q);
endmodule

// File: rtl/dsc_idle_descrambler.sv
module dsc_idle_descrambler
  import dsc_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int LOCK_RUN = 32,
  parameter int TEST_RUN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_present,
  input  logic [LANES-1:0] rx_bits,
  input  logic [LANES-1:0] rx_valid,
  input  logic             test_mode,
  output logic [LANES-1:0] plain_bits,
  output logic [LANES-1:0] plain_valid,
  output logic             locked
);
  key_t             key_q;
  key_t             key_chain [LANES+1];
  logic [LANES-1:0] lane_plain, lane_agree, lane_miss;
  logic             lock_now;
  logic             eff_lock;

  assign eff_lock     = lock_now & sig_present;  // R6: lost signal means unlocked handling
  assign key_chain[0] = key_q;

  // R3: lane 0 sees the register first, lane 1 sees lane 0's result
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dsc_lane_step u_step (
      .key_in (key_chain[g]),
      .locked (eff_lock),
      .rx_bit (rx_bits[g]),
      .rx_vld (rx_valid[g]),
      .key_out(key_chain[g+1]),
      .plain  (lane_plain[g]),
      .agree  (lane_agree[g]),
      .miss   (lane_miss[g])
    );
  end

  dsc_lock_ctrl #(
    .LANES(LANES), .LOCK_RUN(LOCK_RUN), .TEST_RUN(TEST_RUN)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_present(sig_present),
    .test_mode  (test_mode),
    .agree      (lane_agree),
    .miss       (lane_miss),
    .locked     (lock_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin  // R8
      key_q       <= '0;
      plain_bits  <= '0;
      plain_valid <= '0;
    end else begin
      key_q       <= key_chain[LANES];
      plain_bits  <= lane_plain;
      plain_valid <= rx_valid;  // R2
    end
  end

  assign locked = lock_now;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (plain_valid == $past(rx_valid)));
  a_r2_key_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid == '0) |=> $stable(key_q));
endmodule

// File: tb/tb_dsc_idle_descrambler.sv
module tb_dsc_idle_descrambler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig = 1'b0;
  logic       tm = 1'b0;
  logic [1:0] rxb = 2'b00;
  logic [1:0] rxv = 2'b00;
  logic [1:0] pb, pv;
  logic       lk;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dsc_idle_descrambler dut (
    .clk(clk), .rst_n(rst_n), .sig_present(sig), .rx_bits(rxb), .rx_valid(rxv),
    .test_mode(tm), .plain_bits(pb), .plain_valid(pv), .locked(lk)
  );

  // phase: [15:8] cycles, [7] sig, [6] test mode, [5:4] lanes, [3:2] data kind
  // (0 idle ones, 1 pseudo-random, 2 zeros), [1] lock expected at end
  localparam int NPH = 14;
  localparam logic [15:0] PH [NPH] = '{
    {8'd20, 1'b0, 1'b0, 2'b11, 2'd0, 1'b0, 1'b0},
    {8'd40, 1'b1, 1'b0, 2'b11, 2'd0, 1'b1, 1'b0},
    {8'd30, 1'b1, 1'b0, 2'b11, 2'd1, 1'b1, 1'b0},
    {8'd20, 1'b1, 1'b0, 2'b01, 2'd1, 1'b1, 1'b0},
    {8'd20, 1'b1, 1'b0, 2'b10, 2'd1, 1'b1, 1'b0},
    {8'd10, 1'b1, 1'b0, 2'b00, 2'd1, 1'b1, 1'b0},
    {8'd20, 1'b1, 1'b0, 2'b11, 2'd1, 1'b1, 1'b0},
    {8'd3,  1'b0, 1'b0, 2'b11, 2'd0, 1'b0, 1'b0},
    {8'd12, 1'b1, 1'b0, 2'b01, 2'd0, 1'b0, 1'b0},
    {8'd5,  1'b1, 1'b0, 2'b11, 2'd2, 1'b0, 1'b0},
    {8'd40, 1'b1, 1'b0, 2'b11, 2'd0, 1'b1, 1'b0},
    {8'd3,  1'b0, 1'b0, 2'b11, 2'd0, 1'b0, 1'b0},
    {8'd10, 1'b1, 1'b1, 2'b11, 2'd0, 1'b1, 1'b0},
    {8'd20, 1'b1, 1'b1, 2'b11, 2'd1, 1'b1, 1'b0}
  };

  // transmitter side
  logic [10:0] tx_key = 11'h5A3;
  logic [6:0]  prbs = 7'h35;
  // receiver model
  logic [10:0] mk = '0;
  int          mcnt = 0;
  logic        mlock = 1'b0;
  logic [1:0]  exp_b, sent;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at a negedge, update the model, then sample at the next negedge.
  task automatic run_cycle(input logic s, input logic t, input logic [1:0] vm, input logic [1:0] dk);
    logic was_locked;
    logic kb, pl, pk, dec;
    was_locked = mlock && s;
    exp_b = 2'b00;
    for (int l = 0; l < 2; l++) begin
      if (vm[l]) begin
        pl = (dk == 2'd0) ? 1'b1 : (dk == 2'd1) ? prbs[6] : 1'b0;
        prbs = {prbs[5:0], prbs[6] ^ prbs[5]};
        kb = tx_key[8] ^ tx_key[10];
        tx_key = {tx_key[9:0], kb};
        rxb[l] = pl ^ kb;
        sent[l] = pl;
        // model (R1, R4): predict, decode, learn or free-run
        pk = mk[8] ^ mk[10];
        dec = rxb[l] ^ pk;
        exp_b[l] = dec;
        if (was_locked) mk = {mk[9:0], pk};
        else begin
          mk = {mk[9:0], ~rxb[l]};
          if (!mlock) mcnt = dec ? ((mcnt < 32) ? mcnt + 1 : mcnt) : 0;
        end
      end else begin
        rxb[l] = 1'b1;  // noise on an invalid lane must be ignored (R2)
        sent[l] = 1'b0;
      end
    end
    sig = s; tm = t; rxv = vm;
    if (!s) begin mlock = 1'b0; mcnt = 0; end
    else if (!mlock && mcnt >= (t ? 4 : 32)) mlock = 1'b1;
    @(negedge clk);
    check(pv == vm, "R2 valid", pv, vm);
    check(pb == exp_b, "R1 R2 bits", pb, exp_b);
    check(lk == mlock, "R4 R5 lock timing", lk, mlock);
    if (was_locked)
      for (int l = 0; l < 2; l++)
        if (vm[l]) check(pb[l] == sent[l], "R3 decoded data", pb[l], sent[l]);
  endtask

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check(lk == 1'b0 && pv == 2'b00 && pb == 2'b00, "R8 reset outputs", {lk, pv, pb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lk == 1'b0 && pv == 2'b00, "R8 after reset", {lk, pv}, 0);
    for (int p = 0; p < NPH; p++) begin
      for (int c = 0; c < int'(PH[p][15:8]); c++)
        run_cycle(PH[p][7], PH[p][6], PH[p][5:4], PH[p][3:2]);
      tag = !PH[p][7] ? "R6 phase end" : PH[p][6] ? "R7 phase end" : "R5 phase end";
      check(lk == PH[p][1], tag, lk, PH[p][1]);
    end
    // R7: the test-mode lock must come quickly; R5 one drop then one idle cycle stays unlocked
    run_cycle(1'b0, 1'b0, 2'b11, 2'd0);
    check(lk == 1'b0, "R6 drop", lk, 0);
    run_cycle(1'b1, 1'b1, 2'b11, 2'd0);
    check(lk == 1'b0, "R7 two bits short of four", lk, 0);
    run_cycle(1'b1, 1'b1, 2'b11, 2'd0);
    check(lk == 1'b1, "R7 four bits lock", lk, 1);
    // R8: reset in mid-run clears lock and valids
    rxv = 2'b11; rst_n = 1'b0;
    @(negedge clk);
    check(lk == 1'b0 && pv == 2'b00 && pb == 2'b00, "R8 mid-run reset", {lk, pv, pb}, 0);
    rst_n = 1'b1; mk = '0; mcnt = 0; mlock = 1'b0;
    run_cycle(1'b1, 1'b0, 2'b00, 2'd0);
    check(pv == 2'b00 && pb == 2'b00, "R2 no lanes", {pv, pb}, 0);
    run_cycle(1'b1, 1'b0, 2'b10, 2'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule